// File: doc/BRIEF.md
# 4-bit Accumulator Datapath with Carry-Driven Skip

This block is the execution core of a small 4-bit controller. It holds three pieces of architectural state: an accumulator, an auxiliary register and a carry flag. Each cycle in which a valid strobe is presented, it carries out one operation on that state. The operation is named by a 3-bit code. An external sequencer fetches and decodes instructions and drives that code, together with the current RAM nibble, a 4-bit immediate and an 8-bit table word read from program memory.

The carry out of the shared adder goes to a different place depending on the operation. Add-with-carry stores the carry in the persistent flag. Add-immediate leaves the flag alone and instead raises a skip-next pulse in the same cycle, which the sequencer uses to step over the following instruction. The accumulator is always visible on a RAM write-data port, so a store needs nothing from this block. The two 4-bit registers can be exchanged, copied one into the other, or loaded together as one byte.

Top module: `accdp_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the accumulator, auxiliary register and carry flag all become zero on that edge.
- R2: Code 1 (add with carry), when strobed, writes the low 4 bits of accumulator + `ram_rd` + carry flag into the accumulator and writes the carry out of that sum into the carry flag.
- R3: Code 2 (add immediate), when strobed, writes the low 4 bits of accumulator + `imm` into the accumulator. The carry flag does not take part in the sum and is left unchanged.
- R4: `skip_next` is high in a cycle exactly when `op_valid` is high, the code is 2 and accumulator + `imm` is 16 or more. It is low in every other cycle.
- R5: Code 3 exchanges the accumulator and the auxiliary register on one edge.
- R6: Code 4 copies the accumulator into the auxiliary register and leaves the accumulator unchanged.
- R7: Code 5 copies the auxiliary register into the accumulator and leaves the auxiliary register unchanged.
- R8: Code 6 loads `tbl_word[7:4]` into the auxiliary register and `tbl_word[3:0]` into the accumulator on the same edge.
- R9: Code 7 writes `imm[0]` into the carry flag (1 sets, 0 clears) and leaves both data registers unchanged.
- R10: Code 0, or any cycle with `op_valid` low, changes no state, whatever the code and data inputs carry.
- R11: `ram_wd` always equals the current accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Operation code (0 idle, 1 add-carry, 2 add-imm, 3 exchange, 4 A to X, 5 X to A, 6 table, 7 carry control) |
| ram_rd | input | 4 | RAM nibble read for the current operation |
| imm | input | 4 | Immediate operand; bit 0 is the flag value for code 7 |
| tbl_word | input | 8 | Table byte from program memory |
| acc_q | output | 4 | Accumulator |
| aux_q | output | 4 | Auxiliary register |
| cflag_q | output | 1 | Carry flag |
| ram_wd | output | 4 | RAM write data (mirrors the accumulator) |
| skip_next | output | 1 | Request to skip the following instruction |

## Verification
The hardest case to reach is an add-immediate that must use an accumulator value and a flag value chosen so the test can tell the two carry paths apart. The flag has to be set while the accumulator sits at 15, so that a sum feeding the flag in as carry-in would overflow and a correct one would not. The stimulus builds that state on purpose: a table load places 15 in the accumulator, carry control sets the flag, and only then is add-immediate with a zero immediate applied. The test then checks that no skip pulse appears and the flag stays set. A second sequence starts from a clear flag and checks the overflow boundary at sums of exactly 15 and 16.

// File: rtl/accdp_pkg.sv
// Shared definitions for the accumulator datapath: operation codes,
// per-register source selects and the decoded control word.
package accdp_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_ADC  = 3'd1,
        OP_ADX  = 3'd2,
        OP_EXAX = 3'd3,
        OP_A2X  = 3'd4,
        OP_X2A  = 3'd5,
        OP_TBL  = 3'd6,
        OP_CFLG = 3'd7
    } opcode_e;

    typedef enum logic [1:0] {
        ASEL_KEEP = 2'd0,
        ASEL_SUM  = 2'd1,
        ASEL_AUX  = 2'd2,
        ASEL_TLO  = 2'd3
    } acc_sel_e;

    typedef enum logic [1:0] {
        XSEL_KEEP = 2'd0,
        XSEL_ACC  = 2'd1,
        XSEL_THI  = 2'd2
    } aux_sel_e;

    typedef enum logic [1:0] {
        CSEL_KEEP = 2'd0,
        CSEL_COUT = 2'd1,
        CSEL_IMM  = 2'd2
    } c_sel_e;

    typedef struct packed {
        acc_sel_e acc_sel;
        aux_sel_e aux_sel;
        c_sel_e   c_sel;
        logic     operand_imm;  // adder B operand: 1 = immediate, 0 = RAM
        logic     carry_in_en;  // feed the stored flag into the adder
        logic     skip_en;      // adder carry drives skip_next
    } ctrl_t;

endpackage

// File: rtl/accdp_decode.sv
// Operation decoder.
// Turns the strobe and the 3-bit code into register source selects and
// adder controls. It is purely combinational and assumes the code is stable
// while op_valid is high. With the strobe low, every select is KEEP.
module accdp_decode
    import accdp_pkg::*;
(
    input  logic       op_valid,
    input  logic [2:0] op_code,
    output ctrl_t      ctrl
);

    // Map each operation onto the selects it needs; defaults hold all state.
    always_comb begin
        ctrl             = '0;
        ctrl.acc_sel     = ASEL_KEEP;
        ctrl.aux_sel     = XSEL_KEEP;
        ctrl.c_sel       = CSEL_KEEP;
        if (op_valid) begin
            case (opcode_e'(op_code))
                OP_NOP:  ;
                OP_ADC: begin
                    ctrl.acc_sel     = ASEL_SUM;
                    ctrl.c_sel       = CSEL_COUT;
                    ctrl.carry_in_en = 1'b1;
                end
                OP_ADX: begin
                    ctrl.acc_sel     = ASEL_SUM;
                    ctrl.operand_imm = 1'b1;
                    ctrl.skip_en     = 1'b1;
                end
                OP_EXAX: begin
                    ctrl.acc_sel = ASEL_AUX;
                    ctrl.aux_sel = XSEL_ACC;
                end
                OP_A2X:  ctrl.aux_sel = XSEL_ACC;
                OP_X2A:  ctrl.acc_sel = ASEL_AUX;
                OP_TBL: begin
                    ctrl.acc_sel = ASEL_TLO;
                    ctrl.aux_sel = XSEL_THI;
                end
                OP_CFLG: ctrl.c_sel = CSEL_IMM;
            endcase
        end
    end

endmodule

// File: rtl/accdp_ripple_add.sv
// Parameterised ripple-carry adder.
// Built from one full-adder cell per bit. It assumes W is at least 1.
// Carry out is the final stage of the chain.
module accdp_ripple_add #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    logic [W:0] chain;

    // Seed the carry chain with the incoming carry.
    assign chain[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // One full-adder stage.
        assign sum[i]     = a[i] ^ b[i] ^ chain[i];
        assign chain[i+1] = (a[i] & b[i]) | (chain[i] & (a[i] ^ b[i]));
    end

    // Expose the last carry.
    assign cout = chain[W];

endmodule

// File: rtl/accdp_regs.sv
// Architectural state: accumulator, auxiliary register and carry flag.
// Each register loads from the source its select names. The exchange reads
// the old values of both registers, which is safe because all three are
// updated on the same edge. Reset is synchronous and active low.
module accdp_regs
    import accdp_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  ctrl_t          ctrl,
    input  logic [W-1:0]   sum_i,
    input  logic           cout_i,
    input  logic           flag_imm_i,
    input  logic [2*W-1:0] tbl_i,
    output logic [W-1:0]   acc_q,
    output logic [W-1:0]   aux_q,
    output logic           c_q
);

    logic [W-1:0] acc_d;
    logic [W-1:0] aux_d;
    logic         c_d;

    // Accumulator next-value mux.
    always_comb begin
        case (ctrl.acc_sel)
            ASEL_SUM: acc_d = sum_i;
            ASEL_AUX: acc_d = aux_q;
            ASEL_TLO: acc_d = tbl_i[W-1:0];
            default:  acc_d = acc_q;
        endcase
    end

    // Auxiliary register next-value mux.
    always_comb begin
        case (ctrl.aux_sel)
            XSEL_ACC: aux_d = acc_q;
            XSEL_THI: aux_d = tbl_i[2*W-1:W];
            default:  aux_d = aux_q;
        endcase
    end

    // Carry flag next-value mux.
    always_comb begin
        case (ctrl.c_sel)
            CSEL_COUT: c_d = cout_i;
            CSEL_IMM:  c_d = flag_imm_i;
            default:   c_d = c_q;
        endcase
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            aux_q <= '0;
            c_q   <= 1'b0;
        end else begin
            acc_q <= acc_d;
            aux_q <= aux_d;
            c_q   <= c_d;
        end
    end

endmodule

// File: rtl/accdp_top.sv
// Top of the accumulator datapath.
// It picks the adder operand (RAM or immediate) and gates the stored flag
// into the carry-in only for add-with-carry. The add-immediate carry goes
// straight to skip_next in the strobe cycle. It assumes the inputs are
// stable for the whole strobed cycle.
module accdp_top #(
    parameter int unsigned W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           op_valid,
    input  logic [2:0]     op_code,
    input  logic [W-1:0]   ram_rd,
    input  logic [W-1:0]   imm,
    input  logic [2*W-1:0] tbl_word,
    output logic [W-1:0]   acc_q,
    output logic [W-1:0]   aux_q,
    output logic           cflag_q,
    output logic [W-1:0]   ram_wd,
    output logic           skip_next
);

    import accdp_pkg::*;

    ctrl_t        ctrl;
    logic [W-1:0] opnd_b;
    logic         add_cin;
    logic [W-1:0] add_sum;
    logic         add_cout;

    accdp_decode u_dec (
        .op_valid (op_valid),
        .op_code  (op_code),
        .ctrl     (ctrl)
    );

    // Adder operand and carry-in selection.
    assign opnd_b  = ctrl.operand_imm ? imm : ram_rd;
    assign add_cin = ctrl.carry_in_en & cflag_q;

    accdp_ripple_add #(.W(W)) u_add (
        .a    (acc_q),
        .b    (opnd_b),
        .cin  (add_cin),
        .sum  (add_sum),
        .cout (add_cout)
    );

    accdp_regs #(.W(W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl       (ctrl),
        .sum_i      (add_sum),
        .cout_i     (add_cout),
        .flag_imm_i (imm[0]),
        .tbl_i      (tbl_word),
        .acc_q      (acc_q),
        .aux_q      (aux_q),
        .c_q        (cflag_q)
    );

    // Outputs: store data mirrors A; skip is the add-immediate carry.
    assign ram_wd    = acc_q;
    assign skip_next = ctrl.skip_en & add_cout;

endmodule

// File: rtl/accdp_checker.sv
// Protocol and state checker for accdp_top, attached with bind.
// Reads only the top-level ports.
module accdp_checker #(
    parameter int unsigned W = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           op_valid,
    input logic [2:0]     op_code,
    input logic [W-1:0]   ram_rd,
    input logic [W-1:0]   imm,
    input logic [2*W-1:0] tbl_word,
    input logic [W-1:0]   acc_q,
    input logic [W-1:0]   aux_q,
    input logic           cflag_q,
    input logic [W-1:0]   ram_wd,
    input logic           skip_next
);

    import accdp_pkg::*;

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (acc_q == '0 && aux_q == '0 && !cflag_q));

    assert_adc_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_ADC) |=>
        ({cflag_q, acc_q} == ({1'b0, $past(acc_q)} + {1'b0, $past(ram_rd)}
                              + {{W{1'b0}}, $past(cflag_q)})));

    assert_adx_keeps_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_ADX) |=> $stable(cflag_q));

    assert_skip_only_adx_R4: assert property (@(posedge clk) disable iff (!rst_n)
        skip_next |-> (op_valid && op_code == OP_ADX));

    assert_exchange_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_EXAX) |=>
        (acc_q == $past(aux_q) && aux_q == $past(acc_q)));

    assert_table_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_TBL) |=> ({aux_q, acc_q} == $past(tbl_word)));

    assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || op_code == OP_NOP) |=>
        ($stable(acc_q) && $stable(aux_q) && $stable(cflag_q)));

    assert_store_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wd == acc_q);

endmodule

bind accdp_top accdp_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .ram_rd    (ram_rd),
    .imm       (imm),
    .tbl_word  (tbl_word),
    .acc_q     (acc_q),
    .aux_q     (aux_q),
    .cflag_q   (cflag_q),
    .ram_wd    (ram_wd),
    .skip_next (skip_next)
);

// File: tb/sim_accdp_top.sv
// Directed bench for accdp_top: one task per scenario, model kept from the
// requirements, outputs sampled 1 ns after the edge that changes them.
module sim_accdp_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [2:0] op_code = 3'd0;
    logic [3:0] ram_rd = 4'd0;
    logic [3:0] imm = 4'd0;
    logic [7:0] tbl_word = 8'd0;
    logic [3:0] acc_q, aux_q, ram_wd;
    logic       cflag_q, skip_next;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    logic [3:0] ma = 4'd0, mx = 4'd0;
    logic       mc = 1'b0;

    always #5 clk = ~clk;

    accdp_top u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .ram_rd(ram_rd), .imm(imm), .tbl_word(tbl_word),
        .acc_q(acc_q), .aux_q(aux_q), .cflag_q(cflag_q),
        .ram_wd(ram_wd), .skip_next(skip_next)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_state(input string req);
        chk(req, "acc", {4'd0, acc_q}, {4'd0, ma});
        chk(req, "aux", {4'd0, aux_q}, {4'd0, mx});
        chk(req, "cflag", {7'd0, cflag_q}, {7'd0, mc});
    endtask

    // Drive one cycle, check same-cycle outputs, then state after the edge.
    task automatic apply(input string req, input logic v, input logic [2:0] op,
                         input logic [3:0] r, input logic [3:0] im,
                         input logic [7:0] t);
        logic [4:0] s;
        logic       exp_skip;
        @(negedge clk);
        op_valid = v; op_code = op; ram_rd = r; imm = im; tbl_word = t;
        #1;
        s = {1'b0, ma} + {1'b0, im};
        exp_skip = v && op == 3'd2 && s[4];
        chk(req, "skip_next", {7'd0, skip_next}, {7'd0, exp_skip});
        chk("R11", "ram_wd", {4'd0, ram_wd}, {4'd0, ma});
        @(posedge clk);
        if (v) begin
            case (op)
                3'd1: begin s = {1'b0, ma} + {1'b0, r} + {4'd0, mc}; ma = s[3:0]; mc = s[4]; end
                3'd2: ma = ma + im;
                3'd3: begin s[3:0] = ma; ma = mx; mx = s[3:0]; end
                3'd4: mx = ma;
                3'd5: ma = mx;
                3'd6: begin mx = t[7:4]; ma = t[3:0]; end
                3'd7: mc = im[0];
                default: ;
            endcase
        end
        #1;
        chk_state(req);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk); rst_n = 1'b0; op_valid = 1'b0;
        @(posedge clk); #1;
        ma = 4'd0; mx = 4'd0; mc = 1'b0;
        chk_state("R1");
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_adc;
        apply("R2", 1'b1, 3'd6, 4'd0, 4'd0, 8'h39);
        apply("R2", 1'b1, 3'd1, 4'd4, 4'd0, 8'h00);   // 9+4+0 = 13, C=0
        apply("R2", 1'b1, 3'd1, 4'd5, 4'd0, 8'h00);   // 13+5 = 18 -> 2, C=1
        apply("R2", 1'b1, 3'd1, 4'd0, 4'd0, 8'h00);   // 2+0+1 = 3, C=0
        apply("R2", 1'b1, 3'd7, 4'd0, 4'd1, 8'h00);
        apply("R2", 1'b1, 3'd1, 4'hC, 4'd0, 8'h00);   // 3+12+1 = 16 -> 0, C=1
    endtask

    task automatic t_adx_flag;
        apply("R3", 1'b1, 3'd6, 4'd0, 4'd0, 8'h0F);
        apply("R3", 1'b1, 3'd7, 4'd0, 4'd1, 8'h00);   // C=1, A=F
        apply("R3", 1'b1, 3'd2, 4'd0, 4'd0, 8'h00);   // F+0: no skip, C stays 1
        apply("R3", 1'b1, 3'd2, 4'd0, 4'd3, 8'h00);   // F+3 = 2 carry, C stays 1
    endtask

    task automatic t_skip;
        apply("R4", 1'b1, 3'd7, 4'd0, 4'd0, 8'h00);
        apply("R4", 1'b1, 3'd6, 4'd0, 4'd0, 8'h0A);
        apply("R4", 1'b1, 3'd2, 4'd0, 4'd5, 8'h00);   // 10+5 = 15: no skip
        apply("R4", 1'b1, 3'd2, 4'd0, 4'd1, 8'h00);   // 15+1 = 16: skip
        apply("R4", 1'b0, 3'd2, 4'd0, 4'hF, 8'h00);   // not strobed
        apply("R4", 1'b1, 3'd1, 4'hF, 4'hF, 8'h00);   // other add: no skip
    endtask

    task automatic t_moves;
        apply("R8", 1'b1, 3'd6, 4'd0, 4'd0, 8'hA5);
        apply("R5", 1'b1, 3'd3, 4'd0, 4'd0, 8'h00);
        apply("R6", 1'b1, 3'd6, 4'd0, 4'd0, 8'h17);
        apply("R6", 1'b1, 3'd4, 4'd0, 4'd0, 8'h00);
        apply("R7", 1'b1, 3'd6, 4'd0, 4'd0, 8'hC2);
        apply("R7", 1'b1, 3'd5, 4'd0, 4'd0, 8'h00);
        apply("R8", 1'b1, 3'd6, 4'd0, 4'd0, 8'h3E);
    endtask

    task automatic t_flag_ctl;
        apply("R9", 1'b1, 3'd7, 4'd0, 4'hF, 8'h00);
        apply("R9", 1'b1, 3'd7, 4'd0, 4'hE, 8'h00);
        apply("R9", 1'b1, 3'd7, 4'd0, 4'd1, 8'h00);
    endtask

    task automatic t_idle;
        apply("R10", 1'b1, 3'd0, 4'hF, 4'hF, 8'hFF);
        apply("R10", 1'b0, 3'd6, 4'hF, 4'hF, 8'h00);
        apply("R10", 1'b0, 3'd1, 4'hF, 4'hF, 8'h00);
        apply("R10", 1'b0, 3'd7, 4'd0, 4'd0, 8'h00);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        t_reset();
        t_adc();
        t_adx_flag();
        t_skip();
        t_moves();
        t_flag_ctl();
        t_idle();
        t_reset();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule